// File: doc/BRIEF.md
# DMA Controller Register Front End

This block is the register side of a multi-channel DMA controller. It decodes a 4 KB window on a simple single-cycle 32-bit read/write bus and holds the programming words of every channel: source address, destination address, linked-list pointer, control and configuration. It also holds the global controller configuration. The channel count is a parameter, normally 8, with 2 as the reduced variant.

The transfer engine sits outside. It reports terminal-count and error events as one-cycle pulses per channel. The block keeps each event as a pending bit until software clears it by writing ones. The interrupt enables for each channel sit inside that channel's configuration word. The block forms masked status views from them and drives one interrupt line. A fixed run of identification bytes at the top of the window tells software which variant it is talking to.

A read is presented in one cycle, and the data appears on the read port after the next clock edge. The data reflects the state from before that edge. A write takes effect at the edge that ends its cycle.

Top module: `dmac_regfile`

## Requirements
- R1: After a synchronous active-low reset, every channel word, every pending bit, the controller enable and the read data are zero, and the interrupt output is low.
- R2: Channel n owns byte offsets 0x100 + 0x20*n. Word slot addr[4:2] picks the register: 0 source, 1 destination, 2 list pointer, 3 control, 4 configuration. Each register stores a full 32-bit write. Read data appears on the port one clock edge after the read cycle and holds until the next read.
- R3: Accesses to slots 5 to 7 of a channel, or to a channel index at or above the channel count, write nothing and read as zero.
- R4: A pulse on bit n of the terminal-count or error set input makes pending bit n of that kind 1 from the next edge on. Raw terminal-count bits read at 0x14 and raw error bits at 0x18, with bit n for channel n.
- R5: A write to 0x08 clears the terminal-count pending bits written as 1, and a write to 0x10 does the same for the error bits. Bits written as 0 are left unchanged, and no other write clears a pending bit.
- R6: When a set pulse and a clear write reach the same pending bit in the same cycle, the bit ends up set.
- R7: Configuration bit 15 of channel n enables its terminal-count interrupt and bit 14 enables its error interrupt. The masked terminal-count status at 0x04 is raw & enable. The masked error status is at 0x0C. Offset 0x00 returns the OR of the two masked views.
- R8: The interrupt output is high exactly when some masked terminal-count bit or masked error bit is set. It follows the stored state with no added register.
- R9: Offset 0x1C returns a bitmap in which bit n is bit 0 of channel n's configuration word.
- R10: Offset 0x30 holds the controller enable in bit 0. Bits 1 and 2, the endianness select, are not stored because only little-endian operation exists, so they read 0 like every other upper bit.
- R11: Words 0xFE0 to 0xFFC return one identification byte each, in the low 8 bits, in this order: 0x80 for 8 channels or 0x81 for 2 channels, then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1.
- R12: Every other offset, including the request words 0x20 to 0x2C, the write-only clear words and the status words, reads as zero where it has no content. Writes to these offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel_i | input | 1 | Access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address in the window, word aligned |
| bus_wdata_i | input | DW | Write data |
| tc_set_i | input | NUM_CH | Terminal-count event pulses from the engine |
| err_set_i | input | NUM_CH | Error event pulses from the engine |
| bus_rdata_o | output | DW | Read data, valid after the edge that ends the read cycle |
| irq_o | output | 1 | Combined interrupt |

## Verification
Read data is due one edge after the read cycle and carries the state from before that edge. Writes and set pulses show up in the pending bits and in the interrupt from the same edge onward, so the interrupt is due one edge after its cause. The bench drives inputs on the falling edge and updates a behavioural model at the rising edge, in the same order as the design: read first, then the write, then the pending update. At the next falling edge it compares the interrupt on every cycle, and the read port on every cycle that follows a read. This lines up each expected value with the edge at which it is due.

// File: rtl/dmac_pkg.sv
// dmac_pkg: shared constants of the DMA register front end.
// Assumes a 12-bit byte address window and word-aligned accesses.
package dmac_pkg;
    localparam int REGS_PER_CH = 5;
    localparam int SLOT_CFG    = 4;

    // Global register word indices (byte offset >> 2).
    localparam logic [9:0] W_STAT     = 10'h000;
    localparam logic [9:0] W_TC_STAT  = 10'h001;
    localparam logic [9:0] W_TC_CLR   = 10'h002;
    localparam logic [9:0] W_ERR_STAT = 10'h003;
    localparam logic [9:0] W_ERR_CLR  = 10'h004;
    localparam logic [9:0] W_TC_RAW   = 10'h005;
    localparam logic [9:0] W_ERR_RAW  = 10'h006;
    localparam logic [9:0] W_EN_MAP   = 10'h007;
    localparam logic [9:0] W_GCFG     = 10'h00C;

    // Bit positions inside a channel configuration word.
    localparam int CFG_EN_BIT     = 0;
    localparam int CFG_ERR_IE_BIT = 14;
    localparam int CFG_TC_IE_BIT  = 15;

    // Identification byte for word idx of the top 32-byte block.
    function automatic logic [7:0] id_byte(input logic [2:0] idx, input int nch);
        case (idx)
            3'd0:    id_byte = (nch == 8) ? 8'h80 : 8'h81;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h04;
            3'd3:    id_byte = 8'h0A;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/dmac_chan_regs.sv
// dmac_chan_regs: storage for the five programming words of each channel.
// Assumes the caller has already checked the channel index and the slot.
// we_i is only raised for a legal channel and a slot below REGS_PER_CH.
module dmac_chan_regs
    import dmac_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DW     = 32,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CH_W-1:0]  ch_i,
    input  logic [2:0]       slot_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    words_o [NUM_CH][REGS_PER_CH]
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar s = 0; s < REGS_PER_CH; s++) begin : g_slot
            logic [DW-1:0] word_q;

            // Load this word when its channel and slot are addressed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (we_i && ch_i == CH_W'(c) && slot_i == 3'(s)) begin
                    word_q <= wdata_i;
                end
            end

            assign words_o[c][s] = word_q;
        end
    end
endmodule

// File: rtl/dmac_pend.sv
// dmac_pend: one vector of sticky pending bits with write-one-to-clear.
// A set pulse overrides a clear of the same bit in the same cycle.
module dmac_pend #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_i,
    input  logic              clr_we_i,
    input  logic [NUM_CH-1:0] clr_bits_i,
    output logic [NUM_CH-1:0] pend_o
);
    logic [NUM_CH-1:0] clr_eff;

    // Clear mask is active only during a clear write.
    always_comb clr_eff = clr_we_i ? clr_bits_i : '0;

    // Clear first, then merge new events so that set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= (pend_o & ~clr_eff) | set_i;
    end
endmodule

// File: rtl/dmac_rd_mux.sv
// dmac_rd_mux: combinational read decode of the whole register window.
// Assumes word_addr_i is byte address [11:2]. Unmapped words return zero.
module dmac_rd_mux
    import dmac_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DW     = 32,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [9:0]        word_addr_i,
    input  logic [DW-1:0]     words_i [NUM_CH][REGS_PER_CH],
    input  logic [NUM_CH-1:0] tc_pend_i,
    input  logic [NUM_CH-1:0] err_pend_i,
    input  logic [NUM_CH-1:0] tc_mask_i,
    input  logic [NUM_CH-1:0] err_mask_i,
    input  logic [NUM_CH-1:0] en_map_i,
    input  logic              gcfg_en_i,
    output logic [DW-1:0]     rdata_o
);
    logic [2:0]        ch_idx;
    logic [2:0]        slot;
    logic              ch_ok;
    logic              slot_ok;
    logic [NUM_CH-1:0] tc_masked;
    logic [NUM_CH-1:0] err_masked;

    // Field split of the word address and the masked views.
    always_comb begin
        ch_idx     = word_addr_i[5:3];
        slot       = word_addr_i[2:0];
        ch_ok      = int'(ch_idx) < NUM_CH;
        slot_ok    = int'(slot) < REGS_PER_CH;
        tc_masked  = tc_pend_i & tc_mask_i;
        err_masked = err_pend_i & err_mask_i;
    end

    // Select the word addressed by the bus.
    always_comb begin
        rdata_o = '0;
        if (word_addr_i[9:6] == 4'h1) begin
            if (ch_ok && slot_ok) rdata_o = words_i[ch_idx[CH_W-1:0]][slot];
        end else if (word_addr_i[9:3] == 7'h7F) begin
            rdata_o = DW'(id_byte(word_addr_i[2:0], NUM_CH));
        end else begin
            case (word_addr_i)
                W_STAT:     rdata_o = DW'(tc_masked | err_masked);
                W_TC_STAT:  rdata_o = DW'(tc_masked);
                W_ERR_STAT: rdata_o = DW'(err_masked);
                W_TC_RAW:   rdata_o = DW'(tc_pend_i);
                W_ERR_RAW:  rdata_o = DW'(err_pend_i);
                W_EN_MAP:   rdata_o = DW'(en_map_i);
                W_GCFG:     rdata_o = DW'(gcfg_en_i);
                default:    rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/dmac_regfile.sv
// dmac_regfile: register front end of a multi-channel DMA controller.
// Decodes a 4 KB window and keeps channel words and pending event bits.
// Drives one interrupt. Assumes single-cycle word-aligned accesses and DW >= 16.
module dmac_regfile
    import dmac_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DW     = 32,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [11:0]       bus_addr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    input  logic [NUM_CH-1:0] tc_set_i,
    input  logic [NUM_CH-1:0] err_set_i,
    output logic [DW-1:0]     bus_rdata_o,
    output logic              irq_o
);
    logic [9:0]        word_addr;
    logic              wr_cyc;
    logic              rd_cyc;
    logic              chan_we;
    logic              tc_clr_we;
    logic              err_clr_we;
    logic              gcfg_we;
    logic              gcfg_en_q;
    logic [DW-1:0]     words [NUM_CH][REGS_PER_CH];
    logic [NUM_CH-1:0] tc_pend;
    logic [NUM_CH-1:0] err_pend;
    logic [NUM_CH-1:0] tc_mask;
    logic [NUM_CH-1:0] err_mask;
    logic [NUM_CH-1:0] en_map;
    logic [DW-1:0]     rd_word;
    logic              unused_lsbs;

    assign unused_lsbs = ^bus_addr_i[1:0];
    assign word_addr   = bus_addr_i[11:2];

    // Decode the access into write strobes.
    always_comb begin
        wr_cyc     = bus_sel_i && bus_wr_i;
        rd_cyc     = bus_sel_i && !bus_wr_i;
        chan_we    = wr_cyc && word_addr[9:6] == 4'h1
                     && int'(word_addr[5:3]) < NUM_CH
                     && int'(word_addr[2:0]) < REGS_PER_CH;
        tc_clr_we  = wr_cyc && word_addr == W_TC_CLR;
        err_clr_we = wr_cyc && word_addr == W_ERR_CLR;
        gcfg_we    = wr_cyc && word_addr == W_GCFG;
    end

    dmac_chan_regs #(.NUM_CH(NUM_CH), .DW(DW)) chan_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (chan_we),
        .ch_i    (word_addr[3 +: CH_W]),
        .slot_i  (word_addr[2:0]),
        .wdata_i (bus_wdata_i),
        .words_o (words)
    );

    // Gather the per-channel enables from the configuration words.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
        assign tc_mask[c]  = words[c][SLOT_CFG][CFG_TC_IE_BIT];
        assign err_mask[c] = words[c][SLOT_CFG][CFG_ERR_IE_BIT];
        assign en_map[c]   = words[c][SLOT_CFG][CFG_EN_BIT];
    end

    dmac_pend #(.NUM_CH(NUM_CH)) tc_pend_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (tc_set_i),
        .clr_we_i   (tc_clr_we),
        .clr_bits_i (bus_wdata_i[NUM_CH-1:0]),
        .pend_o     (tc_pend)
    );

    dmac_pend #(.NUM_CH(NUM_CH)) err_pend_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (err_set_i),
        .clr_we_i   (err_clr_we),
        .clr_bits_i (bus_wdata_i[NUM_CH-1:0]),
        .pend_o     (err_pend)
    );

    // Controller enable; endianness bits are not kept.
    always_ff @(posedge clk) begin
        if (!rst_n)       gcfg_en_q <= 1'b0;
        else if (gcfg_we) gcfg_en_q <= bus_wdata_i[0];
    end

    dmac_rd_mux #(.NUM_CH(NUM_CH), .DW(DW)) rd_mux_i (
        .word_addr_i (word_addr),
        .words_i     (words),
        .tc_pend_i   (tc_pend),
        .err_pend_i  (err_pend),
        .tc_mask_i   (tc_mask),
        .err_mask_i  (err_mask),
        .en_map_i    (en_map),
        .gcfg_en_i   (gcfg_en_q),
        .rdata_o     (rd_word)
    );

    // Capture the read word at the edge ending the read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata_o <= '0;
        else if (rd_cyc) bus_rdata_o <= rd_word;
    end

    // Interrupt straight from the stored state.
    always_comb irq_o = |(tc_pend & tc_mask) || |(err_pend & err_mask);
endmodule

// File: rtl/dmac_regfile_chk.sv
// dmac_regfile_chk: temporal checks on the register front end.
// Bound into every dmac_regfile instance and observes its ports and pending state.
module dmac_regfile_chk
    import dmac_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel_i,
    input logic              bus_wr_i,
    input logic [11:0]       bus_addr_i,
    input logic [DW-1:0]     bus_wdata_i,
    input logic [NUM_CH-1:0] tc_set_i,
    input logic [NUM_CH-1:0] err_set_i,
    input logic [DW-1:0]     bus_rdata_o,
    input logic              irq_o,
    input logic [NUM_CH-1:0] tc_pend,
    input logic [NUM_CH-1:0] err_pend
);
    logic tc_clr_cyc;
    logic err_clr_cyc;

    // Recognise clear writes from the bus ports.
    always_comb begin
        tc_clr_cyc  = bus_sel_i && bus_wr_i && bus_addr_i[11:2] == W_TC_CLR;
        err_clr_cyc = bus_sel_i && bus_wr_i && bus_addr_i[11:2] == W_ERR_CLR;
    end

    p_tc_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_set_i != '0) |=> ((tc_pend & $past(tc_set_i)) == $past(tc_set_i)));

    p_err_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set_i != '0) |=> ((err_pend & $past(err_set_i)) == $past(err_set_i)));

    p_tc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tc_clr_cyc |=> ((tc_pend & $past(bus_wdata_i[NUM_CH-1:0]) & ~$past(tc_set_i)) == '0));

    p_tc_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_clr_cyc |=> ((tc_pend & $past(tc_pend)) == $past(tc_pend)));

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr_cyc |=> ((err_pend & $past(err_pend)) == $past(err_pend)));

    p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_cyc && err_set_i != '0) |=> ((err_pend & $past(err_set_i)) == $past(err_set_i)));

    p_quiet_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pend == '0 && err_pend == '0) |-> !irq_o);

    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel_i && !bus_wr_i) |=> $stable(bus_rdata_o));
endmodule

bind dmac_regfile dmac_regfile_chk #(.NUM_CH(NUM_CH), .DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .tc_set_i    (tc_set_i),
    .err_set_i   (err_set_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .tc_pend     (tc_pend),
    .err_pend    (err_pend)
);

// File: tb/dmac_regfile_tb_top.sv
// Bench: a behavioural model updated at each rising edge and compared at each falling edge.
module dmac_regfile_tb_top;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [7:0]  tc_set = '0;
    logic [7:0]  err_set = '0;
    logic [31:0] rdata;
    logic        irq;

    int    total = 0;
    int    bad = 0;
    string cur_tag = "R1";
    string m_tag = "R1";
    bit    rd_due = 0;
    bit    done = 0;

    logic [31:0] m_word [8][5];
    logic [7:0]  m_tc, m_err;
    logic        m_gen;
    logic [31:0] m_rd;

    always #2 clk = ~clk;

    dmac_regfile #(.NUM_CH(NCH), .DW(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .tc_set_i(tc_set),
        .err_set_i(err_set), .bus_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [7:0] m_tcmask();
        logic [7:0] m;
        for (int c = 0; c < NCH; c++) m[c] = m_word[c][4][15];
        return m;
    endfunction

    function automatic logic [7:0] m_errmask();
        logic [7:0] m;
        for (int c = 0; c < NCH; c++) m[c] = m_word[c][4][14];
        return m;
    endfunction

    function automatic logic m_irq();
        return ((m_tc & m_tcmask()) != 0) || ((m_err & m_errmask()) != 0);
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        int ch = int'(a[7:5]);
        int sl = int'(a[4:2]);
        logic [7:0] en;
        logic [7:0] ids [8];
        ids = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int c = 0; c < NCH; c++) en[c] = m_word[c][4][0];
        if (a >= 12'h100 && a < 12'h200) return (ch < NCH && sl < 5) ? m_word[ch][sl] : 32'h0;
        if (a >= 12'hFE0) return {24'h0, ids[sl]};
        case (a)
            12'h000: return {24'h0, (m_tc & m_tcmask()) | (m_err & m_errmask())};
            12'h004: return {24'h0, m_tc & m_tcmask()};
            12'h00C: return {24'h0, m_err & m_errmask()};
            12'h014: return {24'h0, m_tc};
            12'h018: return {24'h0, m_err};
            12'h01C: return {24'h0, en};
            12'h030: return {31'h0, m_gen};
            default: return 32'h0;
        endcase
    endfunction

    // Reference update in the design's order: read, write, pending.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 8; c++) for (int s = 0; s < 5; s++) m_word[c][s] = '0;
            m_tc = '0; m_err = '0; m_gen = 0; m_rd = '0; rd_due = 0;
        end else begin
            logic [7:0] ctc, cerr;
            ctc = '0; cerr = '0;
            rd_due = sel && !wr;
            if (rd_due) begin
                m_rd = m_read(addr);
                m_tag = cur_tag;
            end
            if (sel && wr) begin
                if (addr >= 12'h100 && addr < 12'h200 && int'(addr[7:5]) < NCH && int'(addr[4:2]) < 5)
                    m_word[addr[7:5]][addr[4:2]] = wdata;
                if (addr == 12'h030) m_gen = wdata[0];
                if (addr == 12'h008) ctc = wdata[7:0];
                if (addr == 12'h010) cerr = wdata[7:0];
            end
            m_tc  = (m_tc & ~ctc) | tc_set;
            m_err = (m_err & ~cerr) | err_set;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare away from the rising edge.
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                check("R1", {31'h0, irq}, 32'h0);
                check("R1", rdata, 32'h0);
            end else begin
                check("R8", {31'h0, irq}, {31'h0, m_irq()});
                if (rd_due) check(m_tag, rdata, m_rd);
            end
        end
    end

    task automatic cyc(input logic s, input logic w, input logic [11:0] a, input logic [31:0] d,
                       input logic [7:0] ts, input logic [7:0] es, input string tag);
        @(negedge clk);
        sel = s; wr = w; addr = a; wdata = d; tc_set = ts; err_set = es; cur_tag = tag;
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d);
        cyc(1, 1, a, d, 8'h0, 8'h0, "W");
    endtask

    task automatic rd32(input logic [11:0] a, input string tag);
        cyc(1, 0, a, 32'h0, 8'h0, 8'h0, tag);
    endtask

    task automatic idle();
        cyc(0, 0, 12'h0, 32'h0, 8'h0, 8'h0, "I");
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values through the read port
        rd32(12'h100, "R1"); rd32(12'h000, "R1"); rd32(12'h014, "R1");
        rd32(12'h01C, "R1"); rd32(12'h030, "R1");
        // R2: fill and read back every channel word
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < 5; s++)
                wr32(12'h100 + 12'(c * 32 + s * 4), 32'hC0DE0000 | 32'(c << 8) | 32'(s));
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < 5; s++)
                rd32(12'h100 + 12'(c * 32 + s * 4), "R2");
        // R3: spare slots are ignored
        wr32(12'h114, 32'hDEADBEEF); wr32(12'h11C, 32'hFFFFFFFF);
        rd32(12'h114, "R3"); rd32(12'h11C, "R3"); rd32(12'h110, "R3"); rd32(12'h120, "R3");
        // R4: event pulses set raw bits
        cyc(0, 0, 12'h0, 32'h0, 8'h05, 8'h80, "I");
        idle();
        rd32(12'h014, "R4"); rd32(12'h018, "R4"); rd32(12'h000, "R7");
        // R7: enable masks through configuration words
        wr32(12'h150, 32'h0000_8000);
        rd32(12'h004, "R7"); rd32(12'h000, "R7");
        wr32(12'h1F0, 32'h0000_4001);
        rd32(12'h00C, "R7"); rd32(12'h000, "R7");
        rd32(12'h01C, "R9");
        // R5: write-one-to-clear
        wr32(12'h008, 32'h0000_0004);
        rd32(12'h014, "R5"); rd32(12'h004, "R5");
        wr32(12'h010, 32'h0000_0080);
        rd32(12'h018, "R5");
        cyc(0, 0, 12'h0, 32'h0, 8'h30, 8'h0, "I");
        wr32(12'h008, 32'h0000_0010);
        rd32(12'h014, "R5");
        // R6: set and clear on the same bit
        cyc(1, 1, 12'h008, 32'hFF, 8'h02, 8'h00, "W");
        rd32(12'h014, "R6");
        cyc(1, 1, 12'h010, 32'hFF, 8'h00, 8'h40, "W");
        rd32(12'h018, "R6");
        // R4: read in the same cycle as a pulse sees the old state
        cyc(1, 0, 12'h014, 32'h0, 8'h08, 8'h00, "R4");
        rd32(12'h014, "R4");
        // R8: interrupt from error mask path
        wr32(12'h1D0, 32'h0000_4000);
        idle();
        rd32(12'h000, "R8");
        // R10: controller enable only
        wr32(12'h030, 32'hFFFF_FFFF); rd32(12'h030, "R10");
        wr32(12'h030, 32'h0000_0006); rd32(12'h030, "R10");
        // R11: identification bytes
        for (int k = 0; k < 8; k++) rd32(12'hFE0 + 12'(k * 4), "R11");
        // R12: unmapped and read-only words
        wr32(12'h030, 32'h1);
        for (int k = 0; k < 4; k++) wr32(12'h020 + 12'(k * 4), 32'hFFFF_FFFF);
        wr32(12'h040, 32'hFFFF_FFFF); wr32(12'h000, 32'hFFFF_FFFF);
        wr32(12'h014, 32'hFFFF_FFFF); wr32(12'h800, 32'hFFFF_FFFF);
        for (int k = 0; k < 4; k++) rd32(12'h020 + 12'(k * 4), "R12");
        rd32(12'h008, "R12"); rd32(12'h010, "R12"); rd32(12'h040, "R12");
        rd32(12'h800, "R12"); rd32(12'h014, "R12"); rd32(12'h030, "R12");
        idle(); idle();
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule